// File: doc/BRIEF.md
# Sidetone Filter Control and Coefficient Loader

This block is the register-mapped control point of an audio sidetone path. It holds the tap weights of a downstream FIR filter, a signed gain for each of two channels, a path enable and an auto-idle request. Software reaches it over a plain 32-bit register bus with address, write strobe, read strobe, write data and read data. The read data is combinational in the cycle the read strobe is high. The filter arithmetic, the serial audio port and any clock gating live elsewhere. This block exports the weights, gains and enable to them.

Tap weights arrive through one auto-incrementing port register. A load begins when software raises the load-enable bit in the control register. Software then writes `NUM_TAPS` weights to the port, one per write, and polls the completion flag. A second bank holds the weights the filter sees. That bank keeps the old set until the final weight of a new load is captured, and then takes the whole new set in one cycle. Load completion also raises an interrupt status bit, which software clears by writing a one to it and which can be masked.

Top module: `sidetone_ctrl`

## Requirements
- R1: After a synchronous active-low reset, these hold: the control register reads 0, the system configuration register reads 1 (auto-idle set), the gain register reads 0, the interrupt status and mask read 0, `irq` is low, and every exported weight is 0.
- R2: A read at offset 0x00 returns the parameter `REV_VALUE`. A read at any offset not listed in these requirements returns 0.
- R3: The gain register at offset 0x24 is read/write. Channel 0 gain is bits 15:0 and channel 1 gain is bits 31:16. Both are driven on `gain_ch0` and `gain_ch1` in the cycle after the write.
- R4: Control register (offset 0x2C) bit 0 drives `st_enable`. System configuration (offset 0x10) bit 0 drives `st_autoidle`. Both read back from their registers.
- R5: While control bit 1 (load enable) is high, each write to the port register (offset 0x28) stores its bits 15:0 as the next weight, starting at index 0. `coef_flat[i*16 +: 16]` is weight i. The exported weights do not change until all `NUM_TAPS` weights have been captured. All of them then change together in the cycle after the final write.
- R6: Control bit 2 (load done) reads 1 once `NUM_TAPS` weights have been captured in the current load. Writes to bit 2 have no effect.
- R7: Port writes while load enable is low are ignored. Port writes after the `NUM_TAPS`-th in a load are ignored, and the exported weights keep the completed set.
- R8: Any change of the load-enable bit clears the done flag and returns the weight index to 0. A load restarted part-way through therefore fills from index 0.
- R9: Interrupt status bit 0 (offset 0x18) is set when a load completes. Writing 1 to that bit clears it. `irq` is high exactly when the status bit and mask bit 0 (offset 0x1C) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, else 0 |
| st_enable | output | 1 | Sidetone path enable |
| st_autoidle | output | 1 | Auto-idle request |
| gain_ch0 | output | 16 | Channel 0 gain, signed |
| gain_ch1 | output | 16 | Channel 1 gain, signed |
| coef_flat | output | NUM_TAPS*16 | Committed weights, weight i at bits i*16 +: 16 |
| irq | output | 1 | Load-complete interrupt |

## Verification
The bench builds the block with `NUM_TAPS` set to 8 rather than the default 128, and keeps the default 8-bit address and revision constant. Eight weights are few enough that the bench can check every weight after each load. They still cover every case that depends on the load length: the commit boundary at the final weight, an extra write after a full bank, and a restart part-way through a load. The other registers do not depend on the tap count, so they are checked exactly as the default build would see them.

// File: rtl/st_pkg.sv
// Package: register offsets and bit positions of the sidetone control block.
// Assumes byte addressing with 32-bit registers.
package st_pkg;
    localparam int unsigned OFF_REV    = 'h00;
    localparam int unsigned OFF_SYSCFG = 'h10;
    localparam int unsigned OFF_IRQSTS = 'h18;
    localparam int unsigned OFF_IRQMSK = 'h1C;
    localparam int unsigned OFF_GAIN   = 'h24;
    localparam int unsigned OFF_COEF   = 'h28;
    localparam int unsigned OFF_CTRL   = 'h2C;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_LOAD_BIT = 1;
    localparam int unsigned CTRL_DONE_BIT = 2;
endpackage

// File: rtl/st_coef_loader.sv
// Module: st_coef_loader
// Captures a stream of tap weights into a shadow bank at an auto-incrementing
// index. When the last weight arrives it commits the whole set to the
// exported bank at once. Assumes 'restart' pulses on every change of the
// load-enable level and never coincides with a weight write.
module st_coef_loader #(
    parameter int NUM_TAPS = 128,
    parameter int COEF_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic                       restart,
    input  logic                       coef_wr,
    input  logic [COEF_W-1:0]          coef_data,
    output logic                       load_done,
    output logic                       load_event,
    output logic [NUM_TAPS*COEF_W-1:0] coef_flat
);
    localparam int IDX_W = $clog2(NUM_TAPS + 1);
    localparam int SEL_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(NUM_TAPS);

    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    logic [COEF_W-1:0] shadow_q [NUM_TAPS];
    logic [COEF_W-1:0] active_q [NUM_TAPS];
    logic              accept;

    assign accept     = coef_wr && load_en && !restart && (idx_q < FULL_IDX);
    assign load_event = accept && (idx_q == LAST_IDX);
    assign load_done  = done_q;

    // Index and done flag: reset on restart, advance on each accepted weight.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx_q  <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) done_q <= 1'b1;
        end
    end

    // Shadow bank: store the accepted weight at the current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TAPS; i++) shadow_q[i] <= '0;
        end else if (accept) begin
            shadow_q[idx_q[SEL_W-1:0]] <= coef_data;
        end
    end

    // Exported bank: take the full new set in the cycle the last weight lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TAPS; i++) active_q[i] <= '0;
        end else if (load_event) begin
            for (int i = 0; i < NUM_TAPS - 1; i++) active_q[i] <= shadow_q[i];
            active_q[NUM_TAPS-1] <= coef_data;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_pack
        assign coef_flat[g*COEF_W +: COEF_W] = active_q[g];
    end

    // The exported weights may only move in the cycle the done flag rises.
    assert_atomic_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_flat != $past(coef_flat)) |-> (done_q && !$past(done_q)));
    // The index never runs past a full bank.
    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= FULL_IDX);
    // A change of load enable leaves a fresh load: index 0, not done.
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en != $past(load_en)) |-> (idx_q == '0 && !done_q));
    // Done can only stand while loading is enabled.
    assert_done_needs_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> load_en);
endmodule

// File: rtl/st_irq.sv
// Module: st_irq
// Holds one load-complete status bit, cleared by writing a one to it, and
// one mask bit. A new event in the same cycle as a clear takes priority.
module st_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic sts_clr,
    input  logic msk_wr,
    input  logic msk_val,
    output logic sts,
    output logic msk,
    output logic irq
);
    logic sts_q, msk_q;

    // Status bit: set on completion, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (set_evt) sts_q <= 1'b1;
        else if (sts_clr) sts_q <= 1'b0;
    end

    // Mask bit: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= 1'b0;
        else if (msk_wr) msk_q <= msk_val;
    end

    assign sts = sts_q;
    assign msk = msk_q;
    assign irq = sts_q & msk_q;

    // A completion event always leaves the status bit set.
    assert_status_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts_q);
endmodule

// File: rtl/sidetone_ctrl.sv
// Module: sidetone_ctrl (top)
// Register decode for the sidetone control block. Holds the gain, enable and
// auto-idle registers. Forwards weight writes to the loader and completion
// events to the interrupt logic. Assumes one bus access per cycle; read data
// is combinational while bus_rd is high.
module sidetone_ctrl #(
    parameter int          NUM_TAPS  = 128,
    parameter int          COEF_W    = 16,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] REV_VALUE = 32'h0000_0102
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       st_enable,
    output logic                       st_autoidle,
    output logic [15:0]                gain_ch0,
    output logic [15:0]                gain_ch1,
    output logic [NUM_TAPS*COEF_W-1:0] coef_flat,
    output logic                       irq
);
    import st_pkg::*;

    localparam logic [ADDR_W-1:0] A_REV    = ADDR_W'(OFF_REV);
    localparam logic [ADDR_W-1:0] A_SYSCFG = ADDR_W'(OFF_SYSCFG);
    localparam logic [ADDR_W-1:0] A_IRQSTS = ADDR_W'(OFF_IRQSTS);
    localparam logic [ADDR_W-1:0] A_IRQMSK = ADDR_W'(OFF_IRQMSK);
    localparam logic [ADDR_W-1:0] A_GAIN   = ADDR_W'(OFF_GAIN);
    localparam logic [ADDR_W-1:0] A_COEF   = ADDR_W'(OFF_COEF);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

    logic        en_q, load_q, idle_q;
    logic [31:0] gain_q;
    logic        wr_ctrl, restart, load_done, load_event;
    logic        irq_sts, irq_msk;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign restart = wr_ctrl && (bus_wdata[CTRL_LOAD_BIT] != load_q);

    // Control register: enable and load-enable bits; done is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            load_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[CTRL_EN_BIT];
            load_q <= bus_wdata[CTRL_LOAD_BIT];
        end
    end

    // System configuration: auto-idle comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n)                             idle_q <= 1'b1;
        else if (bus_wr && bus_addr == A_SYSCFG) idle_q <= bus_wdata[0];
    end

    // Gain register: both channel gains in one word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            gain_q <= '0;
        else if (bus_wr && bus_addr == A_GAIN) gain_q <= bus_wdata;
    end

    st_coef_loader #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_q),
        .restart    (restart),
        .coef_wr    (bus_wr && bus_addr == A_COEF),
        .coef_data  (bus_wdata[COEF_W-1:0]),
        .load_done  (load_done),
        .load_event (load_event),
        .coef_flat  (coef_flat)
    );

    st_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (load_event),
        .sts_clr (bus_wr && bus_addr == A_IRQSTS && bus_wdata[0]),
        .msk_wr  (bus_wr && bus_addr == A_IRQMSK),
        .msk_val (bus_wdata[0]),
        .sts     (irq_sts),
        .msk     (irq_msk),
        .irq     (irq)
    );

    // Read mux: zero for unmapped offsets and when no read is strobed.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_REV:    bus_rdata = REV_VALUE;
                A_SYSCFG: bus_rdata = {31'b0, idle_q};
                A_IRQSTS: bus_rdata = {31'b0, irq_sts};
                A_IRQMSK: bus_rdata = {31'b0, irq_msk};
                A_GAIN:   bus_rdata = gain_q;
                A_CTRL:   bus_rdata = {29'b0, load_done, load_q, en_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign st_enable   = en_q;
    assign st_autoidle = idle_q;
    assign gain_ch0    = gain_q[15:0];
    assign gain_ch1    = gain_q[31:16];

    // Interrupt line only rises together with, or after, the status bit.
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_sts);
    // The gain outputs follow the last gain write one cycle later.
    assert_gain_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_GAIN) |=> ({gain_ch1, gain_ch0} == $past(bus_wdata)));
endmodule

// File: tb/tb_sidetone_ctrl.sv
// Bench: a register-access vector table walked by one loop, then directed
// tests for reset, weight loading, restart, overflow and interrupt handling.
module tb_sidetone_ctrl;
    localparam int          TAPS = 8;
    localparam int          CW   = 16;
    localparam logic [31:0] REV  = 32'h0000_0102;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              st_enable, st_autoidle, irq;
    logic [15:0]       gain_ch0, gain_ch1;
    logic [TAPS*CW-1:0] coef_flat;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sidetone_ctrl #(.NUM_TAPS(TAPS), .COEF_W(CW), .ADDR_W(8), .REV_VALUE(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_enable(st_enable),
        .st_autoidle(st_autoidle), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
        .coef_flat(coef_flat), .irq(irq)
    );

    typedef struct packed {
        logic        do_wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0,          REV,           4'd2},  // R2 revision
        '{1'b0, 8'h04, 32'h0,          32'h0,         4'd2},  // R2 unmapped
        '{1'b0, 8'h3C, 32'h0,          32'h0,         4'd2},  // R2 unmapped
        '{1'b1, 8'h24, 32'hFFFE_1234,  32'hFFFE_1234, 4'd3},  // R3 gain
        '{1'b1, 8'h24, 32'h7FFF_8000,  32'h7FFF_8000, 4'd3},  // R3 gain extremes
        '{1'b1, 8'h10, 32'h0,          32'h0,         4'd4},  // R4 idle off
        '{1'b1, 8'h2C, 32'h1,          32'h1,         4'd4},  // R4 enable
        '{1'b1, 8'h2C, 32'h5,          32'h1,         4'd6},  // R6 done bit read-only
        '{1'b1, 8'h1C, 32'h1,          32'h1,         4'd9}   // R9 mask
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] set_a(int i);
        return 16'h8000 ^ 16'(i * 'h0111);
    endfunction
    function automatic logic [15:0] set_b(int i);
        return 16'h0F00 + 16'(i * 3);
    endfunction

    task automatic check_bank(string req, bit use_b);
        for (int i = 0; i < TAPS; i++)
            check(req, 32'(coef_flat[i*CW +: CW]), 32'(use_b ? set_b(i) : set_a(i)));
    endtask

    task automatic check_bank_zero(string req);
        for (int i = 0; i < TAPS; i++)
            check(req, 32'(coef_flat[i*CW +: CW]), 32'h0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(8'h2C, r); check("R1 ctrl", r, 32'h0);
        bus_read(8'h10, r); check("R1 syscfg", r, 32'h1);
        bus_read(8'h24, r); check("R1 gain", r, 32'h0);
        bus_read(8'h18, r); check("R1 irq status", r, 32'h0);
        bus_read(8'h1C, r); check("R1 irq mask", r, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check_bank_zero("R1 weights");

        // Register access table
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].do_wr) bus_write(VECS[v].addr, VECS[v].wdata);
            bus_read(VECS[v].addr, r);
            check($sformatf("R%0d table[%0d]", VECS[v].req, v), r, VECS[v].exp);
        end
        check("R3 gain_ch0", 32'(gain_ch0), 32'h8000);
        check("R3 gain_ch1", 32'(gain_ch1), 32'h7FFF);
        check("R4 st_enable", 32'(st_enable), 32'h1);
        check("R4 st_autoidle", 32'(st_autoidle), 32'h0);
        bus_write(8'h10, 32'h1);
        check("R4 st_autoidle set", 32'(st_autoidle), 32'h1);

        // R7: port write with load disabled is ignored
        bus_write(8'h28, 32'h0000_7777);
        check_bank_zero("R7 write while disabled");

        // R5: load set A; bank holds old values until the last weight
        bus_write(8'h2C, 32'h3);
        for (int i = 0; i < TAPS - 1; i++) bus_write(8'h28, {16'hDEAD, set_a(i)});
        check_bank_zero("R5 before last weight");
        bus_read(8'h2C, r); check("R6 not done yet", r, 32'h3);
        bus_write(8'h28, 32'(set_a(TAPS - 1)));
        check_bank("R5 committed set", 1'b0);
        bus_read(8'h2C, r); check("R6 done", r, 32'h7);
        bus_read(8'h18, r); check("R9 status set", r, 32'h1);
        check("R9 irq high", 32'(irq), 32'h1);

        // R7: extra write after a full bank is ignored
        bus_write(8'h28, 32'h0000_1111);
        check_bank("R7 overflow write", 1'b0);
        bus_read(8'h2C, r); check("R7 still done", r, 32'h7);

        // R9: write-one-to-clear
        bus_write(8'h18, 32'h0);
        bus_read(8'h18, r); check("R9 write zero keeps status", r, 32'h1);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, r); check("R9 cleared", r, 32'h0);
        check("R9 irq low", 32'(irq), 32'h0);

        // R8: clearing load enable clears done
        bus_write(8'h2C, 32'h1);
        bus_read(8'h2C, r); check("R8 done cleared", r, 32'h1);

        // R8: partial load, restart, full load of set B from index 0
        bus_write(8'h2C, 32'h3);
        for (int i = 0; i < 3; i++) bus_write(8'h28, 32'h0000_5555);
        check_bank("R8 partial load leaves bank", 1'b0);
        bus_write(8'h2C, 32'h1);
        bus_write(8'h2C, 32'h3);
        bus_write(8'h1C, 32'h0);
        for (int i = 0; i < TAPS; i++) bus_write(8'h28, 32'(set_b(i)));
        check_bank("R8 restart fills from index 0", 1'b1);

        // R9: masked completion sets status but not irq
        bus_read(8'h18, r); check("R9 status with mask off", r, 32'h1);
        check("R9 irq masked", 32'(irq), 32'h0);
        bus_write(8'h1C, 32'h1);
        check("R9 irq after unmask", 32'(irq), 32'h1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule